// File: doc/BRIEF.md
# Backup-Domain Control Register

This block is a single 32-bit control and status register that sits in an always-on power domain with its own reset. It holds the controls for a low-speed external oscillator: enable, bypass and a drive-strength select. It also holds a read-only oscillator-ready flag, a two-bit real-time-clock source select, a real-time-clock enable and a software request that resets the whole domain. Software reaches it through a simple request/ready port with byte-lane strobes.

Several fields are guarded. The oscillator and clock-source fields change only while an external protection-release input is high. The clock-source select can be set once and then stays locked until the domain is reset. The drive-strength bit can be changed only while the oscillator is off. An access that follows directly on the previous one is stretched with wait states. Only the domain reset input clears the register; no other reset reaches it.

Top module: `bdc_reg`

## Requirements
- R1: After the domain reset the register reads 0x0000_0000, and every control output and `dom_rst_req` is 0.
- R2: Bit map: bit 0 oscillator enable, bit 1 ready flag, bit 2 bypass, bit 3 drive select, bits 9:8 clock source, bit 15 clock enable, bit 16 software domain reset. All other bits read 0, and bit 1 ignores writes.
- R3: Writes to the enable, bypass, clock-source and clock-enable fields take effect only while `wp_off` is 1. With `wp_off` at 0 those fields keep their values.
- R4: The clock-source field uses these codes: 00 none, 01 external low-speed, 10 internal low-speed, 11 divided high-speed. Once it holds a nonzero value it ignores writes until a domain reset or a software domain reset clears it.
- R5: The drive-select bit takes a write only while the stored oscillator enable is 0. This includes a write that sets the enable in the same access.
- R6: While bit 16 is 1, `dom_rst_req` is 1, all other fields are held at 0 and writes to them are ignored. A write of bit 16 = 0 releases it, and the other fields in that same write are still ignored.
- R7: The ready flag shows `osc_rdy_in` after a two-stage synchronizer, ANDed with the stored oscillator enable. It is 0 whenever the enable is 0.
- R8: Byte strobes act on their own lanes. Lane 0 covers bits 7:0, lane 1 covers bits 15:8 and lane 2 covers bits 23:16. An unstrobed lane keeps its fields.
- R9: An access whose request was low in the previous cycle completes in its first cycle. An access that starts in the cycle right after a completed access gets exactly 2 wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| dom_rst_n | input | 1 | Asynchronous active-low domain reset |
| acc_req | input | 1 | Access request, held until `acc_ready` |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_be | input | 4 | Byte-lane strobes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Register image, valid when `acc_ready` is 1 |
| acc_ready | output | 1 | Access completes in this cycle |
| wp_off | input | 1 | Protection release for the guarded fields |
| osc_rdy_in | input | 1 | Asynchronous oscillator-ready input |
| osc_en | output | 1 | Oscillator enable |
| osc_byp | output | 1 | Oscillator bypass |
| osc_hidrv | output | 1 | Oscillator high-drive select |
| rtc_src | output | 2 | Real-time-clock source select |
| rtc_en | output | 1 | Real-time-clock enable |
| dom_rst_req | output | 1 | Software domain-reset request |

## Verification
The hardest state to reach is a write that releases the software domain reset while it also carries nonzero data for the other fields. Those fields must stay at zero. To get there, the bench sets bit 16 through its lane alone, then writes a full word with bit 16 clear and the other fields set, and reads the register back as zero. A second hard case is the drive bit's lock in the same cycle that the oscillator turns off. The bench clears the enable and the drive bit in one write, and expects the drive bit to survive until a second write.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    localparam int REG_W      = 32;
    localparam int BIT_OSC_EN = 0;
    localparam int BIT_RDY    = 1;
    localparam int BIT_BYP    = 2;
    localparam int BIT_HIDRV  = 3;
    localparam int BIT_SRC_LO = 8;
    localparam int BIT_RTC_EN = 15;
    localparam int BIT_SRST   = 16;
    localparam logic [REG_W-1:0] IMG_MASK = 32'h0001_830F;

    typedef struct packed {
        logic       srst;
        logic       rtc_en;
        logic [1:0] rtc_src;
        logic       hidrv;
        logic       osc_byp;
        logic       osc_en;
    } bdc_ctrl_t;

    localparam bdc_ctrl_t CTRL_RESET = '0;

    function automatic logic [REG_W-1:0] bdc_image(bdc_ctrl_t c, logic rdy);
        logic [REG_W-1:0] img;
        img = '0;
        img[BIT_OSC_EN]               = c.osc_en;
        img[BIT_RDY]                  = rdy;
        img[BIT_BYP]                  = c.osc_byp;
        img[BIT_HIDRV]                = c.hidrv;
        img[BIT_SRC_LO+1:BIT_SRC_LO]  = c.rtc_src;
        img[BIT_RTC_EN]               = c.rtc_en;
        img[BIT_SRST]                 = c.srst;
        return img;
    endfunction
endpackage

// File: rtl/bdc_sync.sv
module bdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/bdc_bus_timing.sv
module bdc_bus_timing #(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ready
);
    generate
        if (WAIT_STATES == 0) begin : g_nowait
            assign ready = req;
        end else begin : g_wait
            localparam int CNT_W = $clog2(WAIT_STATES + 1);
            localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_STATES - 1);

            typedef struct packed {
                logic             in_acc;
                logic [CNT_W-1:0] cnt;
                logic             prev_done;
            } tim_t;

            tim_t s_d, s_q;
            logic rdy_c;

            always_comb begin
                s_d   = s_q;
                rdy_c = 1'b0;
                if (!req) begin
                    s_d.in_acc = 1'b0;
                    s_d.cnt    = '0;
                end else if (s_q.in_acc) begin
                    if (s_q.cnt == '0) begin
                        rdy_c      = 1'b1;
                        s_d.in_acc = 1'b0;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end else if (s_q.prev_done) begin
                    s_d.in_acc = 1'b1;
                    s_d.cnt    = CNT_LOAD;
                end else begin
                    rdy_c = 1'b1;
                end
                s_d.prev_done = rdy_c;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end

            assign ready = rdy_c;
        end
    endgenerate
endmodule

// File: rtl/bdc_fields.sv
module bdc_fields
    import bdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wp_off,
    output bdc_ctrl_t        ctrl
);
    bdc_ctrl_t c_d, c_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[31:17], wr_data[14:10], wr_data[7:4], wr_data[BIT_RDY]};

    always_comb begin
        c_d = c_q;
        if (wr_en && !c_q.srst) begin
            if (wr_be[0]) begin
                if (wp_off) begin
                    c_d.osc_en  = wr_data[BIT_OSC_EN];
                    c_d.osc_byp = wr_data[BIT_BYP];
                end
                if (!c_q.osc_en) c_d.hidrv = wr_data[BIT_HIDRV];
            end
            if (wr_be[1] && wp_off) begin
                c_d.rtc_en = wr_data[BIT_RTC_EN];
                if (c_q.rtc_src == 2'b00) c_d.rtc_src = wr_data[BIT_SRC_LO+1:BIT_SRC_LO];
            end
        end
        if (wr_en && wr_be[2]) c_d.srst = wr_data[BIT_SRST];
        if (c_d.srst) begin
            c_d      = CTRL_RESET;
            c_d.srst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CTRL_RESET;
        else        c_q <= c_d;
    end

    assign ctrl = c_q;
endmodule

// File: rtl/bdc_reg.sv
module bdc_reg
    import bdc_pkg::*;
#(
    parameter int WAIT_STATES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        dom_rst_n,
    input  logic        acc_req,
    input  logic        acc_we,
    input  logic [3:0]  acc_be,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_ready,
    input  logic        wp_off,
    input  logic        osc_rdy_in,
    output logic        osc_en,
    output logic        osc_byp,
    output logic        osc_hidrv,
    output logic [1:0]  rtc_src,
    output logic        rtc_en,
    output logic        dom_rst_req
);
    bdc_ctrl_t ctrl;
    logic      rdy_sync;
    logic      wr_en;
    logic      unused_lane3;

    assign unused_lane3 = acc_be[3];

    bdc_bus_timing #(.WAIT_STATES(WAIT_STATES)) u_timing (
        .clk   (clk),
        .rst_n (dom_rst_n),
        .req   (acc_req),
        .ready (acc_ready)
    );

    bdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (dom_rst_n),
        .din   (osc_rdy_in),
        .dout  (rdy_sync)
    );

    assign wr_en = acc_req && acc_ready && acc_we;

    bdc_fields u_fields (
        .clk     (clk),
        .rst_n   (dom_rst_n),
        .wr_en   (wr_en),
        .wr_be   (acc_be[2:0]),
        .wr_data (acc_wdata),
        .wp_off  (wp_off),
        .ctrl    (ctrl)
    );

    assign acc_rdata   = bdc_image(ctrl, ctrl.osc_en & rdy_sync);
    assign osc_en      = ctrl.osc_en;
    assign osc_byp     = ctrl.osc_byp;
    assign osc_hidrv   = ctrl.hidrv;
    assign rtc_src     = ctrl.rtc_src;
    assign rtc_en      = ctrl.rtc_en;
    assign dom_rst_req = ctrl.srst;
endmodule

// File: rtl/bdc_reg_chk.sv
module bdc_reg_chk #(
    parameter int WAIT_STATES = 2
) (
    input logic        clk,
    input logic        dom_rst_n,
    input logic        acc_req,
    input logic        acc_we,
    input logic [3:0]  acc_be,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic        acc_ready,
    input logic        wp_off,
    input logic        osc_en,
    input logic        osc_byp,
    input logic        osc_hidrv,
    input logic [1:0]  rtc_src,
    input logic        rtc_en,
    input logic        dom_rst_req
);
    logic srst_set;
    assign srst_set = acc_req && acc_ready && acc_we && acc_be[2] && acc_wdata[16];

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!dom_rst_n)
        (acc_rdata & ~32'h0001_830F) == 32'h0); // R2

    AST_WP_HOLD: assert property (@(posedge clk) disable iff (!dom_rst_n)
        (!wp_off && !srst_set) |=> ($stable(osc_en) && $stable(osc_byp) && $stable(rtc_en) && $stable(rtc_src))); // R3

    AST_SRC_ONCE: assert property (@(posedge clk) disable iff (!dom_rst_n)
        (rtc_src != 2'b00 && !srst_set) |=> $stable(rtc_src)); // R4

    AST_DRV_LOCK: assert property (@(posedge clk) disable iff (!dom_rst_n)
        (osc_en && !srst_set) |=> $stable(osc_hidrv)); // R5

    AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!dom_rst_n)
        dom_rst_req |-> (!osc_en && !osc_byp && !osc_hidrv && rtc_src == 2'b00 && !rtc_en)); // R6

    AST_RDY_GATED: assert property (@(posedge clk) disable iff (!dom_rst_n)
        !osc_en |-> !acc_rdata[1]); // R7

    AST_ISO_NOWAIT: assert property (@(posedge clk) disable iff (!dom_rst_n)
        (acc_req && !$past(acc_req)) |-> acc_ready); // R9

    generate
        if (WAIT_STATES > 0) begin : g_b2b
            AST_B2B_WAIT: assert property (@(posedge clk) disable iff (!dom_rst_n)
                (acc_req && $past(acc_ready)) |-> !acc_ready); // R9
        end
    endgenerate
endmodule

bind bdc_reg bdc_reg_chk #(.WAIT_STATES(WAIT_STATES)) u_chk (
    .clk         (clk),
    .dom_rst_n   (dom_rst_n),
    .acc_req     (acc_req),
    .acc_we      (acc_we),
    .acc_be      (acc_be),
    .acc_wdata   (acc_wdata),
    .acc_rdata   (acc_rdata),
    .acc_ready   (acc_ready),
    .wp_off      (wp_off),
    .osc_en      (osc_en),
    .osc_byp     (osc_byp),
    .osc_hidrv   (osc_hidrv),
    .rtc_src     (rtc_src),
    .rtc_en      (rtc_en),
    .dom_rst_req (dom_rst_req)
);

// File: tb/bdc_reg_test.sv
`timescale 1ns/1ps
module bdc_reg_test;
    logic        clk = 1'b0;
    logic        dom_rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic [3:0]  acc_be = 4'h0;
    logic [31:0] acc_wdata = 32'h0;
    logic [31:0] acc_rdata;
    logic        acc_ready;
    logic        wp_off = 1'b0;
    logic        osc_rdy_in = 1'b0;
    logic        osc_en, osc_byp, osc_hidrv, rtc_en, dom_rst_req;
    logic [1:0]  rtc_src;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bdc_reg uut (
        .clk(clk), .dom_rst_n(dom_rst_n), .acc_req(acc_req), .acc_we(acc_we),
        .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_ready(acc_ready), .wp_off(wp_off), .osc_rdy_in(osc_rdy_in),
        .osc_en(osc_en), .osc_byp(osc_byp), .osc_hidrv(osc_hidrv),
        .rtc_src(rtc_src), .rtc_en(rtc_en), .dom_rst_req(dom_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [3:0] be, input logic [31:0] wd,
                          input bit keep, output logic [31:0] rd, output int waits);
        acc_req = 1'b1; acc_we = we; acc_be = be; acc_wdata = wd; waits = 0;
        #1;
        while (!acc_ready) begin
            @(negedge clk); #1;
            waits++;
        end
        rd = acc_rdata;
        @(negedge clk);
        if (!keep) begin
            acc_req = 1'b0; acc_we = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] wd);
        logic [31:0] rd; int w;
        access(1'b1, be, wd, 1'b0, rd, w);
    endtask

    task automatic rd_chk(input string req, input logic [31:0] exp);
        logic [31:0] rd; int w;
        access(1'b0, 4'hF, 32'h0, 1'b0, rd, w);
        chk(req, rd, exp);
    endtask

    task automatic hw_reset();
        @(negedge clk);
        dom_rst_n = 1'b0; acc_req = 1'b0; acc_we = 1'b0;
        repeat (2) @(negedge clk);
        dom_rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        hw_reset();
        chk("R1 outputs", {26'h0, osc_en, osc_byp, osc_hidrv, rtc_src, rtc_en}, 32'h0);
        chk("R1 req", {31'h0, dom_rst_req}, 32'h0);
        rd_chk("R1 readback", 32'h0);
    endtask

    task automatic t_layout_src_srst();
        hw_reset();
        wp_off = 1'b1;
        wr(4'b0011, 32'hFFFE_FFFF);
        rd_chk("R2 bit map", 32'h0000_830D);
        chk("R2 outputs", {26'h0, osc_en, osc_byp, osc_hidrv, rtc_src, rtc_en}, {26'h0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1});
        wr(4'b0010, 32'h0000_8100);
        chk("R4 source locked", {30'h0, rtc_src}, 32'h3);
        wr(4'b0100, 32'h0001_0000);
        chk("R6 request", {31'h0, dom_rst_req}, 32'h1);
        rd_chk("R6 fields cleared", 32'h0001_0000);
        wr(4'b1111, 32'h0000_810D);
        rd_chk("R6 release ignores fields", 32'h0);
        chk("R6 request released", {31'h0, dom_rst_req}, 32'h0);
        wr(4'b0010, 32'h0000_0200);
        chk("R4 source writable after soft reset", {30'h0, rtc_src}, 32'h2);
    endtask

    task automatic t_protect_drive();
        hw_reset();
        wp_off = 1'b0;
        wr(4'b0011, 32'h0000_810D);
        rd_chk("R3 protected fields hold", 32'h0000_0008);
        wp_off = 1'b1;
        wr(4'b0011, 32'h0000_810D);
        rd_chk("R3 released write", 32'h0000_810D);
        wr(4'b0011, 32'h0000_8105);
        rd_chk("R5 drive locked while on", 32'h0000_810D);
        wr(4'b0011, 32'h0000_0000);
        rd_chk("R5 drive held in turn-off write", 32'h0000_0108);
        wr(4'b0011, 32'h0000_0000);
        rd_chk("R5 drive cleared when off", 32'h0000_0100);
    endtask

    task automatic t_lanes_ready();
        hw_reset();
        wp_off = 1'b1;
        wr(4'b0001, 32'hFFFF_FFFF);
        rd_chk("R8 lane0 only", 32'h0000_000D);
        wr(4'b0010, 32'hFFFF_FFFF);
        rd_chk("R8 lane1 only", 32'h0000_830D);
        wr(4'b1000, 32'hFFFF_FFFF);
        rd_chk("R8 lane3 no effect", 32'h0000_830D);
        chk("R8 no soft reset", {31'h0, dom_rst_req}, 32'h0);
        osc_rdy_in = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk("R7 ready flag", 32'h0000_830F);
        wr(4'b0001, 32'h0000_0000);
        rd_chk("R7 flag gated by enable", 32'h0000_8308);
        osc_rdy_in = 1'b0;
    endtask

    task automatic t_waits();
        logic [31:0] rd; int w;
        hw_reset();
        access(1'b0, 4'hF, 32'h0, 1'b0, rd, w);
        chk("R9 isolated wait", w, 0);
        access(1'b1, 4'b0001, 32'h0000_0004, 1'b1, rd, w);
        chk("R9 first of chain", w, 0);
        access(1'b0, 4'hF, 32'h0, 1'b1, rd, w);
        chk("R9 second wait", w, 2);
        chk("R9 second data", rd, 32'h0000_0004);
        access(1'b0, 4'hF, 32'h0, 1'b0, rd, w);
        chk("R9 third wait", w, 2);
        access(1'b0, 4'hF, 32'h0, 1'b0, rd, w);
        chk("R9 after gap", w, 0);
    endtask

    initial begin
        t_reset();
        t_layout_src_srst();
        t_protect_drive();
        t_lanes_ready();
        t_waits();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule